// File: doc/BRIEF.md
# Multi-Domain Reset Distribution Controller

This block turns a set of active-low reset requests into the reset outputs of a device with three CPU subsystems. The requests are raw and filtered power-on reset, the external reset pin, a software-simulated external reset, a watchdog reset, an error-monitor watchdog reset and a debugger system reset for each CPU, and a reset from the industrial Ethernet slave. Each request reaches a fixed set of domains: the power-on self-test, the security module, CPU1, CPU2, CPU3 and the debug logic. Requests can also tristate the IOs and pull the external reset pin low.

Every request is brought onto the controller clock through two flops. Each domain output is stretched so that it stays asserted for a minimum number of cycles. It then deasserts on a clock edge. When CPU1 is reset, CPU2 and CPU3 can be kept in reset after CPU1 comes out, one hold-enable bit for each. A held CPU is let go when CPU1 writes its release bit or when the security module raises its release input. A sticky cause register records which requests produced the most recent CPU1 reset.

Top module: `rstd_top`

## Requirements
- R1: The self-test reset output `lpost_rst_n` asserts only for the raw power-on request; no other request touches it.
- R2: Raw and filtered power-on both assert the security, CPU1, CPU2, CPU3 and debug resets, set `io_hiz` and drive `xrs_drive_n` low.
- R3: The external pin request asserts the security and all three CPU resets and sets `io_hiz`, but leaves the debug reset and `xrs_drive_n` alone.
- R4: The simulated external reset, the CPU1 watchdog, the Ethernet-slave reset and the error-monitor watchdog of any CPU assert the security and all three CPU resets, set `io_hiz` and drive `xrs_drive_n` low; the debug reset stays high.
- R5: The CPU1 debugger reset asserts the three CPU resets and sets `io_hiz` only.
- R6: The CPU2 watchdog or debugger reset asserts only `cpu2_rst_n`; the CPU3 pair asserts only `cpu3_rst_n`.
- R7: An output asserts on the third rising edge after its request goes low. It stays asserted for at least 8 cycles. It deasserts on the ninth edge after the synchronized request clears.
- R8: With hold-enable set, CPU2 (or CPU3) stays in reset after a CPU1 reset ends. It leaves reset after a write of its release bit or when `hsm_release` goes high (two-flop synchronized).
- R9: With hold-enable clear, that secondary CPU leaves reset together with CPU1.
- R10: The control register sits at `bus_addr`=0. Bit 0 is the CPU2 hold enable and bit 1 the CPU3 hold enable; both read back and reset to 1 on either power-on request only. Bits 2 and 3 are write-only release strobes for CPU2 and CPU3 and read as 0.
- R11: The cause register sits at `bus_addr`=1. Bit i is request i in the order raw POR, filtered POR, pin, simulated, wd1, nmi1, dbg1, wd2, nmi2, dbg2, wd3, nmi3, dbg3, Ethernet. A CPU1 reset event loads the CPU1-reaching requests that are active. Writing ones clears bits.
- R12: The cause register survives later resets that do not reach CPU1 and is replaced by each new CPU1 event. Any power-on event reloads it.
- R13: Register writes are ignored while `cpu1_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_raw_n | input | 1 | Raw power-on request, active low |
| por_n | input | 1 | Filtered power-on request, active low |
| xrs_pin_n | input | 1 | External reset pin request, active low |
| sim_xrs_n | input | 1 | Software-simulated external reset, active low |
| wdog_n | input | 3 | Watchdog reset per CPU (bit 0 = CPU1), active low |
| nmiwd_n | input | 3 | Error-monitor watchdog reset per CPU, active low |
| dbgsys_n | input | 3 | Debugger system reset per CPU, active low |
| ecat_rst_n | input | 1 | Ethernet-slave reset request, active low |
| hsm_release | input | 1 | Security-module release of held CPUs, active high |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 cause |
| bus_wdata | input | 14 | Write data |
| bus_rdata | output | 14 | Read data for the selected register |
| lpost_rst_n | output | 1 | Self-test domain reset |
| hsm_rst_n | output | 1 | Security-module reset |
| cpu1_rst_n | output | 1 | CPU1 subsystem reset |
| cpu2_rst_n | output | 1 | CPU2 subsystem reset |
| cpu3_rst_n | output | 1 | CPU3 subsystem reset |
| dbg_rst_n | output | 1 | Debug logic reset |
| io_hiz | output | 1 | IO tristate enable, active high |
| xrs_drive_n | output | 1 | Drive low of the external reset pin |

## Verification
The bench pulses each request alone and compares the full domain vector. A wrong routing row therefore shows up as an extra or missing domain, for example a pin reset that also clears debug or a CPU2 watchdog that sets the IO tristate. It checks one-cycle and long pulses on the exact edges where the stretch must still hold and must end, which exposes an off-by-one counter. It tries to clear a hold and the cause register while CPU1 is in reset, where a design that does not block writes loses the hold. It also checks that a CPU2-only reset leaves the recorded cause alone and that a new CPU1 event replaces it rather than accumulating.

// File: rtl/rstd_pkg.sv
// Shared constants for the reset distribution controller: request and
// domain indices and the routing of requests to domains.
// Assumes request and domain vectors are indexed by the constants below.
package rstd_pkg;

    localparam int NSRC = 14;
    localparam int NDOM = 8;

    // request indices (bit order also used by the cause register)
    localparam int S_PORRAW = 0;
    localparam int S_POR    = 1;
    localparam int S_PIN    = 2;
    localparam int S_SIM    = 3;
    localparam int S_WD1    = 4;
    localparam int S_NMI1   = 5;
    localparam int S_DBG1   = 6;
    localparam int S_WD2    = 7;
    localparam int S_NMI2   = 8;
    localparam int S_DBG2   = 9;
    localparam int S_WD3    = 10;
    localparam int S_NMI3   = 11;
    localparam int S_DBG3   = 12;
    localparam int S_ECAT   = 13;

    // domain indices
    localparam int D_LPOST = 0;
    localparam int D_HSM   = 1;
    localparam int D_CPU1  = 2;
    localparam int D_CPU2  = 3;
    localparam int D_CPU3  = 4;
    localparam int D_DBG   = 5;
    localparam int D_IOZ   = 6;
    localparam int D_XRS   = 7;

    typedef logic [NSRC-1:0] src_t;
    typedef logic [NDOM-1:0] dom_t;

    // Domains reached by one request.
    function automatic dom_t route_of(input int s);
        dom_t sys;
        sys = '0;
        sys[D_HSM]  = 1'b1;
        sys[D_CPU1] = 1'b1;
        sys[D_CPU2] = 1'b1;
        sys[D_CPU3] = 1'b1;
        sys[D_IOZ]  = 1'b1;
        case (s)
            S_PORRAW: return '1;
            S_POR: begin
                route_of = '1;
                route_of[D_LPOST] = 1'b0;
            end
            S_PIN: return sys;
            S_SIM, S_WD1, S_NMI1, S_NMI2, S_NMI3, S_ECAT: begin
                route_of = sys;
                route_of[D_XRS] = 1'b1;
            end
            S_DBG1: begin
                route_of = sys;
                route_of[D_HSM] = 1'b0;
            end
            S_WD2, S_DBG2: begin
                route_of = '0;
                route_of[D_CPU2] = 1'b1;
            end
            S_WD3, S_DBG3: begin
                route_of = '0;
                route_of[D_CPU3] = 1'b1;
            end
            default: return '0;
        endcase
    endfunction

    // Requests that reach one domain.
    function automatic src_t srcs_for(input int d);
        dom_t r;
        srcs_for = '0;
        for (int s = 0; s < NSRC; s++) begin
            r = route_of(s);
            srcs_for[s] = r[d];
        end
    endfunction

endpackage

// File: rtl/rstd_sync.sv
// Two-flop synchronizer for a vector of level signals.
// Assumes each bit is an independent slow level; the flops carry no reset
// because they hold the power-on request itself.
module rstd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // two-stage capture onto clk
    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/rstd_stretch.sv
// Stretches an active-high reset request to at least MIN_CYC cycles and
// releases it on a clock edge.
// Assumes MIN_CYC >= 2; the request itself acts as the reset of this stage.
module rstd_stretch #(
    parameter int MIN_CYC = 8
) (
    input  logic clk,
    input  logic req,
    output logic act
);
    localparam int CW = $clog2(MIN_CYC);
    localparam logic [CW-1:0] LOAD = CW'(MIN_CYC - 1);

    logic [CW-1:0] cnt;

    // reload while requested, count down afterwards, then release
    always_ff @(posedge clk) begin
        if (req) begin
            act <= 1'b1;
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            act <= 1'b0;
        end
    end
endmodule

// File: rtl/rstd_regs.sv
// CPU1-side registers: hold enables, release strobes, the held state of the
// secondary CPUs and the sticky reset cause.
// Assumes por_rst_n is the synchronized power-on request (active low) and
// c1_act the stretched CPU1 reset; writes are refused while CPU1 is in reset.
module rstd_regs
    import rstd_pkg::*;
#(
    parameter int NSEC = 2
) (
    input  logic            clk,
    input  logic            por_rst_n,
    input  logic            c1_req,
    input  logic            c1_act,
    input  src_t            c1_src,
    input  logic            rel_s,
    input  logic            bus_wr_en,
    input  logic            bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic [NSEC-1:0] hold_en,
    output logic [NSEC-1:0] held
);
    localparam logic A_CTRL  = 1'b0;
    localparam logic A_CAUSE = 1'b1;

    logic            wr_ok;
    logic [NSEC-1:0] rel_wr;
    src_t            cause;

    assign wr_ok  = bus_wr_en && !c1_act;
    assign rel_wr = (wr_ok && bus_addr == A_CTRL) ? bus_wdata[2*NSEC-1:NSEC] : '0;

    // hold enables: default on at power-on, software writable otherwise
    always_ff @(posedge clk) begin
        if (!por_rst_n)
            hold_en <= '1;
        else if (wr_ok && bus_addr == A_CTRL)
            hold_en <= bus_wdata[NSEC-1:0];
    end

    // per secondary CPU hold latch: set by CPU1 reset, cleared by a release
    for (genvar i = 0; i < NSEC; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!por_rst_n)
                held[i] <= 1'b1;
            else if (c1_act && hold_en[i])
                held[i] <= 1'b1;
            else if (!c1_act && (rel_wr[i] || rel_s))
                held[i] <= 1'b0;
        end
    end

    // sticky cause: loaded per CPU1 event, merged within it, cleared by W1C
    always_ff @(posedge clk) begin
        if (!por_rst_n)
            cause <= c1_src;
        else if (c1_req)
            cause <= c1_act ? (cause | c1_src) : c1_src;
        else if (wr_ok && bus_addr == A_CAUSE)
            cause <= cause & ~bus_wdata;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CAUSE)
            bus_rdata = cause;
        else
            bus_rdata[NSEC-1:0] = hold_en;
    end
endmodule

// File: rtl/rstd_top.sv
// Reset distribution controller for a three-CPU device: synchronizes the
// reset requests, routes each to its domains, stretches every domain reset
// and keeps the secondary CPUs held after a CPU1 reset when enabled.
// Assumes clk runs whenever any reset is requested.
module rstd_top
    import rstd_pkg::*;
#(
    parameter int MIN_CYC = 8
) (
    input  logic            clk,
    input  logic            por_raw_n,
    input  logic            por_n,
    input  logic            xrs_pin_n,
    input  logic            sim_xrs_n,
    input  logic [2:0]      wdog_n,
    input  logic [2:0]      nmiwd_n,
    input  logic [2:0]      dbgsys_n,
    input  logic            ecat_rst_n,
    input  logic            hsm_release,
    input  logic            bus_wr_en,
    input  logic            bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            lpost_rst_n,
    output logic            hsm_rst_n,
    output logic            cpu1_rst_n,
    output logic            cpu2_rst_n,
    output logic            cpu3_rst_n,
    output logic            dbg_rst_n,
    output logic            io_hiz,
    output logic            xrs_drive_n
);
    localparam src_t C1_SRCS = srcs_for(D_CPU1);

    src_t       src_n;
    src_t       src_n_s;
    src_t       src_req;
    logic       rel_s;
    logic       por_req;
    dom_t       dom_req;
    dom_t       dom_act;
    logic [1:0] hold_en_q;
    logic [1:0] held;

    assign src_n = {ecat_rst_n,
                    dbgsys_n[2], nmiwd_n[2], wdog_n[2],
                    dbgsys_n[1], nmiwd_n[1], wdog_n[1],
                    dbgsys_n[0], nmiwd_n[0], wdog_n[0],
                    sim_xrs_n, xrs_pin_n, por_n, por_raw_n};

    rstd_sync #(.W(NSRC + 1)) u_sync (
        .clk (clk),
        .d   ({hsm_release, src_n}),
        .q   ({rel_s, src_n_s})
    );

    assign src_req = ~src_n_s;
    assign por_req = src_req[S_PORRAW] | src_req[S_POR];

    // routing and stretching, one lane per domain
    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        localparam src_t HIT = srcs_for(d);
        assign dom_req[d] = |(src_req & HIT);
        rstd_stretch #(.MIN_CYC(MIN_CYC)) u_str (
            .clk (clk),
            .req (dom_req[d]),
            .act (dom_act[d])
        );
    end

    rstd_regs #(.NSEC(2)) u_regs (
        .clk       (clk),
        .por_rst_n (~por_req),
        .c1_req    (dom_req[D_CPU1]),
        .c1_act    (dom_act[D_CPU1]),
        .c1_src    (src_req & C1_SRCS),
        .rel_s     (rel_s),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hold_en   (hold_en_q),
        .held      (held)
    );

    assign lpost_rst_n = ~dom_act[D_LPOST];
    assign hsm_rst_n   = ~dom_act[D_HSM];
    assign cpu1_rst_n  = ~dom_act[D_CPU1];
    assign cpu2_rst_n  = ~(dom_act[D_CPU2] | held[0]);
    assign cpu3_rst_n  = ~(dom_act[D_CPU3] | held[1]);
    assign dbg_rst_n   = ~dom_act[D_DBG];
    assign io_hiz      = dom_act[D_IOZ];
    assign xrs_drive_n = ~dom_act[D_XRS];
endmodule

// File: rtl/rstd_chk.sv
// Property checker for rstd_top, attached by bind.
// Assumes por_req is the synchronized power-on request of the top.
module rstd_chk #(
    parameter int MIN_CYC = 8
) (
    input logic       clk,
    input logic       por_req,
    input logic [1:0] hold_en,
    input logic       hsm_rst_n,
    input logic       cpu1_rst_n,
    input logic       cpu2_rst_n,
    input logic       cpu3_rst_n,
    input logic       dbg_rst_n,
    input logic       io_hiz,
    input logic       xrs_drive_n
);
    localparam int LW = $clog2(MIN_CYC + 2) + 1;
    logic [LW-1:0] low_cnt;

    // length of the current CPU1 reset pulse, saturating
    always_ff @(posedge clk) begin
        if (cpu1_rst_n)
            low_cnt <= '0;
        else if (low_cnt != '1)
            low_cnt <= low_cnt + 1'b1;
    end

    AST_C1_PULLS_SECONDARY: assert property (@(posedge clk) disable iff (por_req)
        !cpu1_rst_n |-> (!cpu2_rst_n && !cpu3_rst_n)); // R5
    AST_C1_TRISTATES_IO: assert property (@(posedge clk) disable iff (por_req)
        !cpu1_rst_n |-> io_hiz); // R3
    AST_HSM_WITH_C1: assert property (@(posedge clk) disable iff (por_req)
        !hsm_rst_n |-> !cpu1_rst_n); // R4
    AST_XRS_WITH_HSM: assert property (@(posedge clk) disable iff (por_req)
        !xrs_drive_n |-> !hsm_rst_n); // R4
    AST_DBG_WITH_HSM: assert property (@(posedge clk) disable iff (por_req)
        !dbg_rst_n |-> !hsm_rst_n); // R2
    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (por_req)
        $rose(cpu1_rst_n) |-> (low_cnt >= LW'(MIN_CYC))); // R7
    AST_HOLD_CPU2: assert property (@(posedge clk) disable iff (por_req)
        ($rose(cpu1_rst_n) && $past(hold_en[0])) |-> !cpu2_rst_n); // R8
    AST_HOLD_CPU3: assert property (@(posedge clk) disable iff (por_req)
        ($rose(cpu1_rst_n) && $past(hold_en[1])) |-> !cpu3_rst_n); // R8
endmodule

bind rstd_top rstd_chk #(.MIN_CYC(MIN_CYC)) u_chk (
    .clk         (clk),
    .por_req     (por_req),
    .hold_en     (hold_en_q),
    .hsm_rst_n   (hsm_rst_n),
    .cpu1_rst_n  (cpu1_rst_n),
    .cpu2_rst_n  (cpu2_rst_n),
    .cpu3_rst_n  (cpu3_rst_n),
    .dbg_rst_n   (dbg_rst_n),
    .io_hiz      (io_hiz),
    .xrs_drive_n (xrs_drive_n)
);

// File: tb/rstd_top_test.sv
module rstd_top_test;
    logic        clk = 1'b0;
    logic [13:0] src_n;
    logic        hsm_release;
    logic        bus_wr_en;
    logic        bus_addr;
    logic [13:0] bus_wdata;
    logic [13:0] bus_rdata;
    logic lpost_rst_n, hsm_rst_n, cpu1_rst_n, cpu2_rst_n, cpu3_rst_n;
    logic dbg_rst_n, io_hiz, xrs_drive_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rstd_top uut (
        .clk(clk), .por_raw_n(src_n[0]), .por_n(src_n[1]),
        .xrs_pin_n(src_n[2]), .sim_xrs_n(src_n[3]),
        .wdog_n({src_n[10], src_n[7], src_n[4]}),
        .nmiwd_n({src_n[11], src_n[8], src_n[5]}),
        .dbgsys_n({src_n[12], src_n[9], src_n[6]}),
        .ecat_rst_n(src_n[13]), .hsm_release(hsm_release),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lpost_rst_n(lpost_rst_n), .hsm_rst_n(hsm_rst_n),
        .cpu1_rst_n(cpu1_rst_n), .cpu2_rst_n(cpu2_rst_n), .cpu3_rst_n(cpu3_rst_n),
        .dbg_rst_n(dbg_rst_n), .io_hiz(io_hiz), .xrs_drive_n(xrs_drive_n)
    );

    // domain vector, active high: lpost,hsm,cpu1,cpu2,cpu3,dbg,ioz,xrs
    function automatic logic [7:0] dom();
        return {~xrs_drive_n, io_hiz, ~dbg_rst_n, ~cpu3_rst_n, ~cpu2_rst_n,
                ~cpu1_rst_n, ~hsm_rst_n, ~lpost_rst_n};
    endfunction

    // requests that reach CPU1 (cause bits)
    localparam logic [13:0] C1_MASK = 14'h297F;

    // {request mask, expected domains}; routing rows
    localparam int NV = 13;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {14'h0004, 8'h5E},   // pin: R3
        {14'h0008, 8'hDE},   // simulated: R4
        {14'h0010, 8'hDE},   // wd1: R4
        {14'h0020, 8'hDE},   // nmi1: R4
        {14'h0040, 8'h5C},   // dbg1: R5
        {14'h0080, 8'h08},   // wd2: R6
        {14'h0100, 8'hDE},   // nmi2: R4
        {14'h0200, 8'h08},   // dbg2: R6
        {14'h0400, 8'h10},   // wd3: R6
        {14'h0800, 8'hDE},   // nmi3: R4
        {14'h1000, 8'h10},   // dbg3: R6
        {14'h2000, 8'hDE},   // ethernet: R4
        {14'h0480, 8'h18}    // wd2+wd3: R6
    };
    localparam int TAG [0:NV-1] = '{3, 4, 4, 4, 5, 6, 4, 6, 6, 4, 6, 4, 6};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [13:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [13:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // one-cycle pulse on the given requests; returns at the third negedge
    task automatic pulse(input logic [13:0] m);
        src_n = ~m;
        tick(1);
        src_n = '1;
        tick(2);
    endtask

    initial begin
        logic [13:0] v;
        src_n = 14'h3FFC; hsm_release = 1'b0;
        bus_wr_en = 1'b0; bus_addr = 1'b0; bus_wdata = '0;

        tick(6);
        chk("R1 R2 power-on all domains", dom(), 8'hFF);
        src_n = '1;
        tick(12);
        chk("R10 R8 secondaries held after power-on", dom(), 8'h18);
        rd(1'b0, v); chk("R10 hold enables default", v, 14'h3);
        rd(1'b1, v); chk("R12 power-on cause", v, 14'h3);
        wr(1'b0, 14'h7);
        chk("R8 write release cpu2", dom(), 8'h10);
        rd(1'b0, v); chk("R10 release strobes read zero", v, 14'h3);
        hsm_release = 1'b1;
        tick(3);
        chk("R8 security release cpu3", dom(), 8'h00);
        hsm_release = 1'b0;
        tick(2);
        wr(1'b0, 14'h0);
        rd(1'b0, v); chk("R10 hold enables cleared", v, 14'h0);
        wr(1'b1, 14'h3FFF);
        rd(1'b1, v); chk("R11 cause cleared by W1C", v, 14'h0);

        // routing table walk
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][21:8]);
            chk($sformatf("R%0d routing row %0d", TAG[i], i), dom(), VEC[i][7:0]);
            tick(5);
            chk($sformatf("R7 still stretched row %0d", i), dom(), VEC[i][7:0]);
            tick(3);
            chk($sformatf("R7 released row %0d", i), dom(), 8'h00);
            rd(1'b1, v);
            chk($sformatf("R11 cause row %0d", i), v, VEC[i][21:8] & C1_MASK);
            wr(1'b1, 14'h3FFF);
        end

        // hold on cpu2 only, with writes attempted during CPU1 reset
        wr(1'b0, 14'h1);
        pulse(14'h0010);
        tick(1);
        wr(1'b0, 14'h0);
        wr(1'b1, 14'h3FFF);
        tick(7);
        chk("R8 R9 cpu2 held, cpu3 free", dom(), 8'h08);
        rd(1'b0, v); chk("R13 control write blocked in reset", v, 14'h1);
        rd(1'b1, v); chk("R13 cause clear blocked in reset", v, 14'h10);
        pulse(14'h0200);
        tick(9);
        rd(1'b1, v); chk("R12 cause kept over cpu2-only reset", v, 14'h10);
        wr(1'b0, 14'h5);
        chk("R8 cpu2 released by write", dom(), 8'h00);
        pulse(14'h0004);
        tick(9);
        rd(1'b1, v); chk("R12 new event replaces cause", v, 14'h04);
        chk("R8 held again after pin reset", dom(), 8'h08);
        wr(1'b0, 14'h4);
        chk("R8 release with hold cleared", dom(), 8'h00);

        // long request on wd3
        src_n = ~14'h0400;
        tick(3);
        chk("R7 long request asserted", dom(), 8'h10);
        tick(17);
        src_n = '1;
        tick(9);
        chk("R7 long request last cycle", dom(), 8'h10);
        tick(1);
        chk("R7 long request released", dom(), 8'h00);

        // filtered power-on pulse
        pulse(14'h0002);
        chk("R1 R2 filtered power-on", dom(), 8'hFE);
        tick(10);
        chk("R10 secondaries held after filtered power-on", dom(), 8'h18);
        rd(1'b0, v); chk("R10 hold enables restored", v, 14'h3);
        rd(1'b1, v); chk("R12 cause reloaded by power-on", v, 14'h2);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule